// File: doc/BRIEF.md
# SPI EEPROM Burst Controller

This block is an SPI master (mode 0: clock idles low, data is sampled on the rising edge) for a serial EEPROM. The EEPROM is byte-addressed and holds 16-bit words. A requester hands over one request with a handshake. A request is a read or a write, a starting word offset and a word count. The block then runs the whole serial transaction on its own. Read words come back one at a time with a valid pulse. Write words are pulled from the requester one at a time with a pop pulse. A single done pulse, carrying an error code, closes every request.

Before each command group the block checks that the device is ready by polling the device status byte. It gives up after a set number of busy answers. Word offsets are turned into byte addresses, and the two bytes of every word are swapped on the wire. Small devices have an address field only 8 bits wide, so the ninth address bit is carried inside the opcode. Write bursts are cut at device page boundaries, and each new page starts with a fresh ready check and a fresh write-enable.

Top module: `spi_nvm_burst`

## Requirements
- R1: While reset is held, chip select is high (inactive), SCK is low, `req_ready` is high, and `done`, `rd_valid` and `wr_pop` are low.
- R2: A request is rejected in either of these cases: the offset is not below DEV_WORDS, or the count is zero, or offset plus count exceeds DEV_WORDS. A rejected request gets `done` with `err`=1 in the cycle after acceptance, and chip select is never asserted. A request that ends exactly at the last word is accepted.
- R3: Before each command group the block sends status opcode 0x05 and reads 8 bits. A value of 0 in bit 0 means ready. Between two polls chip select goes high and then low again. The number of status commands is one more than the number of busy answers.
- R4: When RETRY_LIMIT status polls in a row all report busy, the block ends the request with `err`=2. No read or write command is sent.
- R5: The address field is the word offset times two, truncated to ADDR_BITS and sent MSB first. When ADDR_BITS is 8 and the segment's first word is 128 or more, the flag 0x08 is ORed into the opcode. Read is 0x03, write is 0x02.
- R6: A read sends one opcode and one address for the whole burst. It then shifts 16 bits per word and gives one `rd_valid` pulse per word, in ascending address order.
- R7: The byte of a word that travels first on the wire is its low byte, both when writing and when reading.
- R8: Each write segment sends write-enable 0x06 and then a chip-select standby pulse, and only then the write opcode and the starting address.
- R9: A write segment ends after a word when the next byte address is a multiple of PAGE_BYTES. The block then raises chip select, polls ready again and opens a new segment.
- R10: SCK is low whenever chip select is high. MOSI does not change while SCK is high.
- R11: `req_ready` is low while chip select is asserted. `done` is a single-cycle pulse and `req_ready` returns the cycle after it. `wr_pop` pulses exactly once per written word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle; request is taken when both are high |
| req_write | input | 1 | 1 = write burst, 0 = read burst |
| req_offset | input | REQ_W | First word offset |
| req_count | input | REQ_W | Number of words |
| wr_word | input | 16 | Next word to write, held until `wr_pop` |
| wr_pop | output | 1 | Current `wr_word` has been taken |
| rd_word | output | 16 | Read word |
| rd_valid | output | 1 | `rd_word` is valid this cycle |
| done | output | 1 | Request finished |
| err | output | 2 | With `done`: 0 ok, 1 range, 2 device not ready |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to device |
| spi_miso | input | 1 | Serial data from device |

## Verification
A wrong byte address or a missing opcode fold shows up in the device model's memory after a single one-word write: the word lands in the wrong byte pair. A missing or misplaced page cut, or a retry count that is off by one, changes the number of write-enable, write and status commands counted in the same request. A byte-order error or a lost word is seen in the first read-back after a write, because every write in the sweep is read back at once and compared word for word.

// File: rtl/nvm_burst_pkg.sv
package nvm_burst_pkg;

  localparam int SHIFT_W = 16;

  localparam logic [7:0] OPC_READ  = 8'h03;
  localparam logic [7:0] OPC_WRITE = 8'h02;
  localparam logic [7:0] OPC_WREN  = 8'h06;
  localparam logic [7:0] OPC_STAT  = 8'h05;
  localparam logic [7:0] OPC_HIADR = 8'h08;

  typedef enum logic [1:0] {
    ERR_NONE  = 2'd0,
    ERR_RANGE = 2'd1,
    ERR_BUSY  = 2'd2
  } nvm_err_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_PCMD, ST_PCMD_W, ST_PSTAT, ST_PSTAT_W, ST_GAP,
    ST_WREN, ST_WREN_W, ST_OPC, ST_OPC_W, ST_ADR, ST_ADR_W,
    ST_DAT, ST_DAT_W, ST_FIN
  } nvm_state_e;

  function automatic logic [15:0] swap16(input logic [15:0] w);
    return {w[7:0], w[15:8]};
  endfunction

endpackage

// File: rtl/nvm_spi_shifter.sv
module nvm_spi_shifter #(
  parameter int CLK_DIV = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [4:0]  nbits,
  input  logic [15:0] tx,
  input  logic        miso,
  output logic        done,
  output logic [15:0] rx,
  output logic        sck,
  output logic        mosi
);
  localparam int TW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [TW-1:0] TMR_LOAD = TW'(CLK_DIV - 1);

  logic          act_q, act_d;
  logic          sck_q, sck_d;
  logic [TW-1:0] tmr_q, tmr_d;
  logic [4:0]    bits_q, bits_d;
  logic [15:0]   tx_q, tx_d;
  logic [15:0]   rx_q, rx_d;
  logic          done_q, done_d;

  always_comb begin
    act_d  = act_q;
    sck_d  = sck_q;
    tmr_d  = tmr_q;
    bits_d = bits_q;
    tx_d   = tx_q;
    rx_d   = rx_q;
    done_d = 1'b0;
    if (start) begin
      act_d  = 1'b1;
      sck_d  = 1'b0;
      tmr_d  = TMR_LOAD;
      bits_d = nbits;
      tx_d   = tx << (5'd16 - nbits);
    end else if (act_q) begin
      if (tmr_q != '0) begin
        tmr_d = tmr_q - 1'b1;
      end else begin
        tmr_d = TMR_LOAD;
        if (!sck_q) begin
          sck_d = 1'b1;
          rx_d  = {rx_q[14:0], miso};
        end else begin
          sck_d  = 1'b0;
          tx_d   = {tx_q[14:0], 1'b0};
          bits_d = bits_q - 1'b1;
          if (bits_q == 5'd1) begin
            act_d  = 1'b0;
            done_d = 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      sck_q  <= 1'b0;
      tmr_q  <= '0;
      bits_q <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
      done_q <= 1'b0;
    end else begin
      act_q  <= act_d;
      sck_q  <= sck_d;
      tmr_q  <= tmr_d;
      bits_q <= bits_d;
      tx_q   <= tx_d;
      rx_q   <= rx_d;
      done_q <= done_d;
    end
  end

  assign done = done_q;
  assign rx   = rx_q;
  assign sck  = sck_q;
  assign mosi = act_q & tx_q[15];
endmodule

// File: rtl/nvm_req_check.sv
module nvm_req_check #(
  parameter int DEV_WORDS = 256,
  parameter int REQ_W     = 16
) (
  input  logic [REQ_W-1:0] offset,
  input  logic [REQ_W-1:0] count,
  output logic             ok
);
  localparam logic [REQ_W:0] LIMIT = (REQ_W+1)'(DEV_WORDS);

  logic [REQ_W:0] end_w;
  assign end_w = {1'b0, offset} + {1'b0, count};
  assign ok = ({1'b0, offset} < LIMIT) && (count != '0) && (end_w <= LIMIT);
endmodule

// File: rtl/nvm_cmd_build.sv
module nvm_cmd_build #(
  parameter int ADDR_BITS  = 8,
  parameter int PAGE_BYTES = 16,
  parameter int REQ_W      = 16
) (
  input  logic             write,
  input  logic [REQ_W-1:0] seg_word,
  input  logic [REQ_W-1:0] next_word,
  output logic [7:0]       opcode,
  output logic [15:0]      addr_field,
  output logic             page_end
);
  import nvm_burst_pkg::*;

  localparam int PB_W = (PAGE_BYTES > 1) ? $clog2(PAGE_BYTES) : 1;

  logic                 fold;
  logic [ADDR_BITS-1:0] a_trunc;
  logic [PB_W-1:0]      nb_low;

  generate
    if (ADDR_BITS == 8) begin : g_fold
      assign fold = (seg_word >= REQ_W'(128));
    end else begin : g_nofold
      assign fold = 1'b0;
    end
  endgenerate

  assign a_trunc    = ADDR_BITS'({seg_word, 1'b0});
  assign addr_field = 16'(a_trunc);
  assign opcode     = (write ? OPC_WRITE : OPC_READ) | (fold ? OPC_HIADR : 8'h00);
  assign nb_low     = PB_W'({next_word, 1'b0});
  assign page_end   = (nb_low == '0);
endmodule

// File: rtl/spi_nvm_burst.sv
module spi_nvm_burst #(
  parameter int DEV_WORDS   = 256,
  parameter int ADDR_BITS   = 8,
  parameter int PAGE_BYTES  = 16,
  parameter int RETRY_LIMIT = 5000,
  parameter int CLK_DIV     = 4,
  parameter int REQ_W       = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [REQ_W-1:0] req_offset,
  input  logic [REQ_W-1:0] req_count,
  input  logic [15:0]      wr_word,
  output logic             wr_pop,
  output logic [15:0]      rd_word,
  output logic             rd_valid,
  output logic             done,
  output logic [1:0]       err,
  output logic             spi_cs_n,
  output logic             spi_sck,
  output logic             spi_mosi,
  input  logic             spi_miso
);
  import nvm_burst_pkg::*;

  localparam int GAP_CYC = 2 * CLK_DIV;
  localparam int GW      = $clog2(GAP_CYC + 1);
  localparam int RW      = $clog2(RETRY_LIMIT + 1);

  logic [1:0] rsync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_ni = rsync_q[1];

  nvm_state_e       st_q, st_d, ret_q, ret_d;
  logic             wr_q, wr_d;
  logic [REQ_W-1:0] word_q, word_d, left_q, left_d;
  logic [RW-1:0]    retry_q, retry_d;
  logic [1:0]       err_q, err_d;
  logic [GW-1:0]    gap_q, gap_d;
  logic [15:0]      rdw_q, rdw_d;
  logic             rdv_q, rdv_d, pop_q, pop_d;
  logic             cs_n_q, cs_n_d;

  logic        sh_start, sh_done, req_ok, page_end;
  logic [4:0]  sh_nbits;
  logic [15:0] sh_tx, sh_rx, addr_field;
  logic [7:0]  opcode;

  nvm_req_check #(.DEV_WORDS(DEV_WORDS), .REQ_W(REQ_W)) u_chk_req (
    .offset(req_offset), .count(req_count), .ok(req_ok)
  );

  nvm_cmd_build #(.ADDR_BITS(ADDR_BITS), .PAGE_BYTES(PAGE_BYTES), .REQ_W(REQ_W)) u_cmd (
    .write(wr_q), .seg_word(word_q), .next_word(word_q + 1'b1),
    .opcode(opcode), .addr_field(addr_field), .page_end(page_end)
  );

  nvm_spi_shifter #(.CLK_DIV(CLK_DIV)) u_shift (
    .clk(clk), .rst_n(rst_ni), .start(sh_start), .nbits(sh_nbits), .tx(sh_tx),
    .miso(spi_miso), .done(sh_done), .rx(sh_rx), .sck(spi_sck), .mosi(spi_mosi)
  );

  always_comb begin
    st_d     = st_q;
    ret_d    = ret_q;
    wr_d     = wr_q;
    word_d   = word_q;
    left_d   = left_q;
    retry_d  = retry_q;
    err_d    = err_q;
    gap_d    = (st_q == ST_GAP && gap_q != '0) ? gap_q - 1'b1 : GW'(GAP_CYC - 1);
    rdw_d    = rdw_q;
    rdv_d    = 1'b0;
    pop_d    = 1'b0;
    sh_start = 1'b0;
    sh_nbits = 5'd8;
    sh_tx    = '0;
    unique case (st_q)
      ST_IDLE: if (req_valid) begin
        wr_d    = req_write;
        word_d  = req_offset;
        left_d  = req_count;
        retry_d = '0;
        if (req_ok) begin err_d = ERR_NONE;  st_d = ST_PCMD; end
        else        begin err_d = ERR_RANGE; st_d = ST_FIN;  end
      end
      ST_PCMD: begin sh_start = 1'b1; sh_tx = 16'(OPC_STAT); st_d = ST_PCMD_W; end
      ST_PCMD_W: if (sh_done) st_d = ST_PSTAT;
      ST_PSTAT: begin sh_start = 1'b1; st_d = ST_PSTAT_W; end
      ST_PSTAT_W: if (sh_done) begin
        if (!sh_rx[0]) begin
          ret_d = wr_q ? ST_WREN : ST_OPC;
          st_d  = ST_GAP;
        end else if (retry_q == RW'(RETRY_LIMIT - 1)) begin
          err_d = ERR_BUSY;
          st_d  = ST_FIN;
        end else begin
          retry_d = retry_q + 1'b1;
          ret_d   = ST_PCMD;
          st_d    = ST_GAP;
        end
      end
      ST_GAP: if (gap_q == '0) st_d = ret_q;
      ST_WREN: begin sh_start = 1'b1; sh_tx = 16'(OPC_WREN); st_d = ST_WREN_W; end
      ST_WREN_W: if (sh_done) begin ret_d = ST_OPC; st_d = ST_GAP; end
      ST_OPC: begin sh_start = 1'b1; sh_tx = 16'(opcode); st_d = ST_OPC_W; end
      ST_OPC_W: if (sh_done) st_d = ST_ADR;
      ST_ADR: begin
        sh_start = 1'b1;
        sh_nbits = 5'(ADDR_BITS);
        sh_tx    = addr_field;
        st_d     = ST_ADR_W;
      end
      ST_ADR_W: if (sh_done) st_d = ST_DAT;
      ST_DAT: begin
        sh_start = 1'b1;
        sh_nbits = 5'd16;
        sh_tx    = wr_q ? swap16(wr_word) : 16'h0000;
        pop_d    = wr_q;
        st_d     = ST_DAT_W;
      end
      ST_DAT_W: if (sh_done) begin
        if (!wr_q) begin
          rdv_d = 1'b1;
          rdw_d = swap16(sh_rx);
        end
        word_d = word_q + 1'b1;
        left_d = left_q - 1'b1;
        if (left_q == REQ_W'(1)) begin
          st_d = ST_FIN;
        end else if (wr_q && page_end) begin
          retry_d = '0;
          ret_d   = ST_PCMD;
          st_d    = ST_GAP;
        end else begin
          st_d = ST_DAT;
        end
      end
      ST_FIN: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
    cs_n_d = (st_d == ST_IDLE) || (st_d == ST_GAP) || (st_d == ST_FIN);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      ret_q   <= ST_IDLE;
      wr_q    <= 1'b0;
      word_q  <= '0;
      left_q  <= '0;
      retry_q <= '0;
      err_q   <= ERR_NONE;
      gap_q   <= '0;
      rdw_q   <= '0;
      rdv_q   <= 1'b0;
      pop_q   <= 1'b0;
      cs_n_q  <= 1'b1;
    end else begin
      st_q    <= st_d;
      ret_q   <= ret_d;
      wr_q    <= wr_d;
      word_q  <= word_d;
      left_q  <= left_d;
      retry_q <= retry_d;
      err_q   <= err_d;
      gap_q   <= gap_d;
      rdw_q   <= rdw_d;
      rdv_q   <= rdv_d;
      pop_q   <= pop_d;
      cs_n_q  <= cs_n_d;
    end
  end

  assign req_ready = (st_q == ST_IDLE);
  assign done      = (st_q == ST_FIN);
  assign err       = err_q;
  assign rd_word   = rdw_q;
  assign rd_valid  = rdv_q;
  assign wr_pop    = pop_q;
  assign spi_cs_n  = cs_n_q;
endmodule

// File: rtl/nvm_burst_chk.sv
module nvm_burst_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic       done,
  input logic [1:0] err,
  input logic       spi_cs_n,
  input logic       spi_sck,
  input logic       spi_mosi
);
  // R10
  cs_idle_sck_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sck);

  // R10
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_sck && $past(spi_sck)) |-> $stable(spi_mosi));

  // R11
  no_accept_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !spi_cs_n |-> !req_ready);

  // R2
  range_reject_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err == 2'd1) |-> $past(req_valid && req_ready));

  // R11
  done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> req_ready);

  // R11
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind spi_nvm_burst nvm_burst_chk u_burst_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .done(done), .err(err), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi)
);

// File: tb/spi_nvm_burst_test.sv
module spi_nvm_burst_test;
  localparam int RL = 6;
  localparam int PG = 8;
  localparam int WR_BUSY = 2;
  localparam int DEVW = 256;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_offset = '0, req_count = '0;
  logic        req_ready, wr_pop, rd_valid, done;
  logic [15:0] wr_word, rd_word;
  logic [1:0]  err;
  logic        spi_cs_n, spi_sck, spi_mosi;
  logic        spi_miso = 1'b0;

  spi_nvm_burst #(.DEV_WORDS(DEVW), .ADDR_BITS(8), .PAGE_BYTES(PG),
                  .RETRY_LIMIT(RL), .CLK_DIV(1), .REQ_W(16)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_offset(req_offset), .req_count(req_count),
    .wr_word(wr_word), .wr_pop(wr_pop), .rd_word(rd_word), .rd_valid(rd_valid),
    .done(done), .err(err), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  int n_cmp = 0, n_bad = 0, cyc = 0;

  task automatic chk_eq(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] pat(input int s, input int i);
    return 16'(s * 40503 + i * 257 + 4660);
  endfunction

  // ---------------- device model ----------------
  logic [7:0] mem [0:511];
  logic [15:0] shadow [0:DEVW-1];
  logic [7:0] m_in = '0, m_out = '0;
  logic [8:0] m_addr = '0;
  int  m_bits = 0, m_phase = 5, busy_left = 0;
  bit  m_wr = 0, m_a8 = 0, m_wel = 0, m_wrote = 0;
  int  n_stat = 0, n_wren = 0, n_rdc = 0, n_wrc = 0, n_csf = 0;

  always @(negedge spi_cs_n) begin
    m_bits = 0; m_phase = 0; m_wrote = 0; n_csf++;
  end

  always @(posedge spi_cs_n) begin
    if (m_phase == 1 && busy_left > 0) busy_left--;
    if (m_wrote) begin busy_left = WR_BUSY; m_wel = 0; m_wrote = 0; end
  end

  always @(posedge spi_sck) if (!spi_cs_n) begin
    m_in = {m_in[6:0], spi_mosi};
    m_bits++;
    if (m_bits % 8 == 0) begin
      case (m_phase)
        0: begin
          if (m_in == 8'h05) begin n_stat++; m_phase = 1; m_out = {7'b0, busy_left != 0}; end
          else if (m_in == 8'h06) begin n_wren++; m_wel = 1; m_phase = 5; end
          else if ((m_in & 8'hF7) == 8'h03) begin n_rdc++; m_wr = 0; m_a8 = m_in[3]; m_phase = 2; end
          else if ((m_in & 8'hF7) == 8'h02) begin n_wrc++; m_wr = 1; m_a8 = m_in[3]; m_phase = 2; end
          else m_phase = 5;
        end
        2: begin
          m_addr = {m_a8, m_in};
          if (m_wr) m_phase = 4;
          else begin m_phase = 3; m_out = mem[m_addr]; end
        end
        3: begin m_addr = m_addr + 9'd1; m_out = mem[m_addr]; end
        4: begin
          if (m_wel) begin mem[m_addr] = m_in; m_wrote = 1; end
          m_addr = (m_addr & ~9'(PG - 1)) | ((m_addr + 9'd1) & 9'(PG - 1));
        end
        default: ;
      endcase
    end
  end

  always @(negedge spi_sck) begin
    spi_miso = m_out[7];
    m_out = {m_out[6:0], 1'b0};
  end

  // ---------------- requester side ----------------
  int seed = 0, wr_idx = 0, rd_idx = 0;
  logic [15:0] rd_buf [0:DEVW-1];
  always_comb wr_word = pat(seed, wr_idx);

  always @(negedge clk) begin
    if (wr_pop) wr_idx++;
    if (rd_valid) begin rd_buf[rd_idx] = rd_word; rd_idx++; end
  end

  // R10 monitor: MOSI must hold while SCK is high, SCK low when CS high
  int viol = 0;
  logic p_sck = 1'b0, p_mosi = 1'b0;
  always @(negedge clk) if (rst_n === 1'b1) begin
    if (p_sck && spi_sck && spi_mosi !== p_mosi) viol++;
    if (spi_cs_n && spi_sck) viol++;
    p_sck = spi_sck; p_mosi = spi_mosi;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 190000) begin
      n_cmp++; n_bad++;
      $display("FAIL R11 watchdog actual=%0d expected=%0d", cyc, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic do_req(input bit wr, input int off, input int cnt, output int e);
    int k;
    wr_idx = 0; rd_idx = 0; e = -1;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_offset = 16'(off); req_count = 16'(cnt);
    @(negedge clk);
    req_valid = 1'b0;
    for (k = 0; k < 40000; k++) begin
      if (done) begin e = int'(err); break; end
      @(negedge clk);
    end
    if (e < 0) chk_eq("R11 done missing", 0, 1);
    @(negedge clk);
  endtask

  task automatic run_write(input int off, input int cnt, input int s);
    int b_wren, b_wrc, segs, e;
    b_wren = n_wren; b_wrc = n_wrc; segs = 1;
    for (int i = 0; i < cnt - 1; i++) if (((off + i + 1) * 2) % PG == 0) segs++;
    seed = s;
    do_req(1'b1, off, cnt, e);
    chk_eq("R9 write err", e, 0);
    chk_eq("R8 write-enable count", n_wren - b_wren, segs);
    chk_eq("R9 segment count", n_wrc - b_wrc, segs);
    chk_eq("R11 pop count", wr_idx, cnt);
    for (int i = 0; i < cnt; i++) shadow[off + i] = pat(s, i);
  endtask

  task automatic run_read(input int off, input int cnt);
    int b_rdc, e;
    b_rdc = n_rdc;
    do_req(1'b0, off, cnt, e);
    chk_eq("R6 read err", e, 0);
    chk_eq("R6 single read command", n_rdc - b_rdc, 1);
    chk_eq("R6 word count", rd_idx, cnt);
    for (int i = 0; i < cnt && i < rd_idx; i++)
      chk_eq("R7 read word", int'(rd_buf[i]), int'(shadow[off + i]));
  endtask

  initial begin
    int e, b, bs, br;
    for (int i = 0; i < 512; i++) mem[i] = 8'(i * 7 + 3);
    for (int w = 0; w < DEVW; w++) shadow[w] = {mem[2*w+1], mem[2*w]};

    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk_eq("R1 cs_n in reset", int'(spi_cs_n), 1);
    chk_eq("R1 sck in reset", int'(spi_sck), 0);
    chk_eq("R1 ready in reset", int'(req_ready), 1);
    chk_eq("R1 pulses in reset", int'({done, rd_valid, wr_pop}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2 rejects: no chip select activity, err 1
    b = n_csf; do_req(1'b0, 256, 1, e);
    chk_eq("R2 offset too large err", e, 1); chk_eq("R2 no frame", n_csf - b, 0);
    b = n_csf; do_req(1'b1, 0, 0, e);
    chk_eq("R2 zero count err", e, 1); chk_eq("R2 no frame", n_csf - b, 0);
    b = n_csf; do_req(1'b0, 250, 7, e);
    chk_eq("R2 overrun err", e, 1); chk_eq("R2 no frame", n_csf - b, 0);
    run_read(250, 6);  // R2 exact fit accepted

    // R4 timeout after RL busy polls
    busy_left = RL; bs = n_stat; br = n_rdc;
    do_req(1'b0, 10, 2, e);
    chk_eq("R4 timeout err", e, 2);
    chk_eq("R4 poll count", n_stat - bs, RL);
    chk_eq("R4 no read command", n_rdc - br, 0);

    // R3 busy RL-1 polls then ready
    busy_left = RL - 1; bs = n_stat;
    run_read(10, 2);
    chk_eq("R3 poll count busy", n_stat - bs, RL);
    bs = n_stat;
    run_read(40, 1);
    chk_eq("R3 poll count idle", n_stat - bs, 1);

    // R5 / R7 byte placement, with and without high-address fold
    run_write(5, 1, 77);
    chk_eq("R7 low byte first", int'(mem[10]), int'(pat(77, 0) & 16'h00FF));
    chk_eq("R5 high byte at addr+1", int'(mem[11]), int'(pat(77, 0) >> 8));
    run_write(200, 1, 91);
    chk_eq("R5 folded address low", int'(mem[400]), int'(pat(91, 0) & 16'h00FF));
    chk_eq("R5 folded address high", int'(mem[401]), int'(pat(91, 0) >> 8));
    run_read(126, 4);

    // R9 / R8 / R6 sweep around the fold point and page edges
    for (int off = 122; off < 134; off++)
      for (int cnt = 1; cnt <= 6; cnt++) begin
        run_write(off, cnt, off * 8 + cnt);
        run_read(off, cnt);
      end

    chk_eq("R10 mosi/sck violations", viol, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule